// File: doc/BRIEF.md
# Dual-Mode Rhythmic Clock Divider

This block turns one external pulse clock into seven slower rhythmic streams at ratios 1, 2, 4, 6, 8, 16 and 32. Each stream has a short trigger output, which marks the start of a cycle, and a gate output that is high for roughly the first half of the cycle. A separate external resync line stops all streams. The streams then wait, and they restart together on the next pulse. Both external lines are asynchronous to the system clock. Each line is passed through a two-stage synchronizer before its rising edge is detected.

Two interpretations of the ratio are available. In raw mode, stream /N starts a cycle on every Nth input pulse. In musical mode, a bar is four quarter notes at a pulse density of 16 or 24 pulses per quarter, which gives 64 or 96 pulses per bar. Stream /N splits that bar into N evenly spaced steps. For this it uses a phase accumulator, so /6 at 64 pulses per bar spreads its six starts as evenly as whole pulses allow.

A small state machine controls the block. It has two states. `ST_WAIT` covers the time after power-up or after a resync; all outputs are silent. `ST_RUN` covers the time when the streams are running. Its transitions are as follows:
- *start*: `ST_WAIT` → `ST_RUN` on a pulse edge.
- *resync*: `ST_RUN` → `ST_WAIT` on a resync edge.
- *advance*: `ST_RUN` → `ST_RUN` on a pulse edge.
- *realign*: `ST_RUN` → `ST_RUN` on a pulse edge that lands on a bar boundary while the mode or density inputs differ from the held setting. All streams restart with the new setting.

Top module: `pulse_divider`

## Requirements
- R1: Bit i of `trig_o` and `gate_o` belongs to ratio 1, 2, 4, 6, 8, 16, 32 for i = 0 to 6.
- R2: Only rising edges of `pulse_in` advance the streams; a pulse first sampled high at a system clock edge produces its trigger outputs after the third edge, and a long high level counts once.
- R3: With `raw_mode` = 1, stream /N starts a cycle on the starting pulse and on every Nth pulse after it.
- R4: With `raw_mode` = 0, a bar is 4 × density pulses, and stream /N starts a cycle on pulse k (counted from 0 at the start) when (k·N mod bar) < N, giving N evenly spaced starts per bar.
- R5: Encodings: `raw_mode` = 0 selects musical mode and `dens_16` = 0 selects 24 pulses per quarter, so tying both low gives musical mode at 24; `dens_16` = 1 selects 16.
- R6: Each cycle start drives the stream's trigger high for exactly TRIG_W system clocks; a new start inside that window reloads the full width.
- R7: In raw mode with N > 1, a gate is high while the pulse count within its cycle is below N/2. In musical mode, a gate is high while its phase (k·N mod bar) is below half the bar.
- R8: In raw mode, the /1 gate equals the synchronized level of `pulse_in` while running.
- R9: After system reset and before the first pulse edge, all outputs are low.
- R10: A rising edge on `resync_in` silences all outputs on the next clock and holds them low until the next pulse edge. That edge restarts every stream together, using the mode and density sampled at that moment.
- R11: A change of mode or density while running takes effect only on a pulse that lands on a bar boundary of the held density (pulse count since start a multiple of the bar). All streams restart on that pulse; before it, the held setting stays in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| pulse_in | input | 1 | External pulse clock, asynchronous |
| resync_in | input | 1 | External resync line, acts on its rising edge, asynchronous |
| raw_mode | input | 1 | 1 = raw pulse-count division, 0 = musical bar division |
| dens_16 | input | 1 | 1 = 16 pulses per quarter, 0 = 24 pulses per quarter |
| trig_o | output | 7 | Trigger outputs, one per ratio |
| gate_o | output | 7 | Gate outputs, one per ratio |

## Verification
The bench builds the block with its default parameters: four beats per bar, densities 16 and 24, and a trigger width of 8 clocks.

These values produce both bar lengths, 96 and 64. At 64, /6 has no integer period, so the uneven 11/10-pulse spacing of the accumulator is checked against a formula. They also make it possible to cross a bar boundary with a pending mode change, which checks that it stays in raw mode until pulse 96.

An 8-clock trigger is longer than a 6-clock input period, so a burst of fast pulses checks retriggering. Slower 20-clock pulses keep every trigger separate, so cycle starts can be counted over a whole bar.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    localparam int NUM_DIV = 7;

    // Ratio of each output bit, lowest bit first (R1)
    localparam int RATIO [NUM_DIV] = '{1, 2, 4, 6, 8, 16, 32};

    typedef enum logic {
        ST_WAIT,
        ST_RUN
    } run_state_e;

    typedef struct packed {
        logic raw;
        logic d16;
    } div_cfg_t;

endpackage

// File: rtl/pdiv_edge_sync.sv
module pdiv_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);

    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], async_i};
        end
    end

    assign level_o = shreg[SYNC_STAGES-1];
    assign rise_o  = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

endmodule

// File: rtl/pdiv_phase.sv
module pdiv_phase #(
    parameter int RATIO  = 1,
    parameter int ACC_W  = 8,
    parameter int TRIG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             restart_i,
    input  logic             advance_i,
    input  logic             raw_i,
    input  logic [ACC_W-1:0] bar_len_i,
    output logic             trig_o,
    output logic             gate_o
);

    localparam int TC_W = $clog2(TRIG_W + 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] modulus;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] acc_nx;
    logic             wrap;
    logic             fire;
    logic [TC_W-1:0]  tcnt;

    always_comb begin
        step    = raw_i ? ACC_W'(1) : ACC_W'(RATIO);
        modulus = raw_i ? ACC_W'(RATIO) : bar_len_i;
        sum     = acc + step;
        wrap    = (sum >= modulus);
        acc_nx  = wrap ? (sum - modulus) : sum;
        fire    = restart_i | (advance_i & wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear_i || restart_i) begin
            acc <= '0;
        end else if (advance_i) begin
            acc <= acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (clear_i) begin
            tcnt <= '0;
        end else if (fire) begin
            tcnt <= TC_W'(TRIG_W);
        end else if (tcnt != '0) begin
            tcnt <= tcnt - 1'b1;
        end
    end

    assign trig_o = (tcnt != '0);
    assign gate_o = (acc < (modulus >> 1));

    // Phase never leaves its modulus (R4)
    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc < modulus);

    // A cycle start is followed by a high trigger (R6)
    assert_fire_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> trig_o);

    // A trigger only rises after a cycle start (R6)
    assert_trig_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> $past(fire));

endmodule

// File: rtl/pulse_divider.sv
module pulse_divider
    import pdiv_pkg::*;
#(
    parameter int BEATS_PER_BAR = 4,
    parameter int DENS_LO       = 16,
    parameter int DENS_HI       = 24,
    parameter int TRIG_W        = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pulse_in,
    input  logic               resync_in,
    input  logic               raw_mode,
    input  logic               dens_16,
    output logic [NUM_DIV-1:0] trig_o,
    output logic [NUM_DIV-1:0] gate_o
);

    localparam int BAR_LO  = BEATS_PER_BAR * DENS_LO;
    localparam int BAR_HI  = BEATS_PER_BAR * DENS_HI;
    localparam int BAR_MAX = (BAR_LO > BAR_HI) ? BAR_LO : BAR_HI;
    localparam int ACC_W   = $clog2(2 * BAR_MAX);

    logic p_level, p_rise;
    logic r_level, r_rise;

    run_state_e       state, state_nx;
    div_cfg_t         cfg, cfg_in;
    logic [ACC_W-1:0] pos, pos_inc, pos_nx, bar_len;
    logic             boundary;
    logic             running, clear, start, realign, restart, advance;

    logic [NUM_DIV-1:0] div_trig;
    logic [NUM_DIV-1:0] div_gate;

    pdiv_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pulse_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pulse_in),
        .level_o (p_level),
        .rise_o  (p_rise)
    );

    pdiv_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_resync_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (resync_in),
        .level_o (r_level),
        .rise_o  (r_rise)
    );

    // Event decode and next state
    always_comb begin
        cfg_in   = '{raw: raw_mode, d16: dens_16};
        bar_len  = cfg.d16 ? ACC_W'(BAR_LO) : ACC_W'(BAR_HI);
        pos_inc  = pos + 1'b1;
        boundary = (pos_inc == bar_len);
        pos_nx   = boundary ? '0 : pos_inc;
        running  = (state == ST_RUN);
        clear    = r_rise;
        start    = !running && p_rise && !r_rise;
        realign  = running && p_rise && !r_rise && boundary && (cfg_in != cfg);
        restart  = start | realign;
        advance  = running && p_rise && !r_rise && !realign;
        state_nx = state;
        unique case (state)
            ST_WAIT: if (start) state_nx = ST_RUN;
            ST_RUN:  if (r_rise) state_nx = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cfg   <= '0;
            pos   <= '0;
        end else begin
            state <= state_nx;
            if (restart) cfg <= cfg_in;
            if (restart || clear) begin
                pos <= '0;
            end else if (advance) begin
                pos <= pos_nx;
            end
        end
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        pdiv_phase #(
            .RATIO  (RATIO[g]),
            .ACC_W  (ACC_W),
            .TRIG_W (TRIG_W)
        ) u_phase (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear),
            .restart_i (restart),
            .advance_i (advance),
            .raw_i     (cfg.raw),
            .bar_len_i (bar_len),
            .trig_o    (div_trig[g]),
            .gate_o    (div_gate[g])
        );
    end

    // Outputs
    always_comb begin
        for (int i = 0; i < NUM_DIV; i++) begin
            trig_o[i] = running & div_trig[i];
            gate_o[i] = running & ((cfg.raw && RATIO[i] == 1) ? p_level : div_gate[i]);
        end
    end

    // All streams start together (R3, R10)
    assert_restart_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (trig_o == '1));

    // Resync edge silences the outputs (R10)
    assert_resync_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_rise |=> (state == ST_WAIT && trig_o == '0 && gate_o == '0));

    // Held setting only changes with a restart (R11)
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(cfg));

    // Bar position stays inside the bar (R11)
    assert_pos_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pos < bar_len);

endmodule

// File: tb/pulse_divider_test.sv
module pulse_divider_test;

    localparam int TW = 8;
    localparam int ND = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic          resync_in = 1'b0;
    logic          raw_mode = 1'b0;
    logic          dens_16 = 1'b0;
    logic [ND-1:0] trig_o;
    logic [ND-1:0] gate_o;

    int rat [ND] = '{1, 2, 4, 6, 8, 16, 32};

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R9";

    pulse_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (pulse_in),
        .resync_in (resync_in),
        .raw_mode  (raw_mode),
        .dens_16   (dens_16),
        .trig_o    (trig_o),
        .gate_o    (gate_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference model
    bit hp [4];
    bit hr [4];
    bit m_run;
    bit m_raw;
    bit m_d16;
    int m_cnt;
    int trem [ND];
    bit fr [ND];
    bit prise;
    bit rrise;
    int bar;

    function automatic int bar_of(input bit d16);
        return d16 ? 64 : 96;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin hp[i] = 0; hr[i] = 0; end
            m_run = 0; m_raw = 0; m_d16 = 0; m_cnt = 0;
            for (int i = 0; i < ND; i++) trem[i] = 0;
        end else begin
            prise = hp[1] && !hp[2];
            rrise = hr[1] && !hr[2];
            for (int i = 0; i < ND; i++) fr[i] = 0;
            if (rrise) begin
                m_run = 0;
                for (int i = 0; i < ND; i++) trem[i] = 0;
            end else if (prise) begin
                if (!m_run) begin
                    m_run = 1; m_raw = raw_mode; m_d16 = dens_16; m_cnt = 0;
                    for (int i = 0; i < ND; i++) fr[i] = 1;
                end else begin
                    m_cnt++;
                    bar = bar_of(m_d16);
                    if ((m_cnt % bar) == 0 && (raw_mode != m_raw || dens_16 != m_d16)) begin
                        m_raw = raw_mode; m_d16 = dens_16; m_cnt = 0;
                        for (int i = 0; i < ND; i++) fr[i] = 1;
                    end else begin
                        for (int i = 0; i < ND; i++)
                            fr[i] = m_raw ? ((m_cnt % rat[i]) == 0)
                                          : (((m_cnt * rat[i]) % bar) < rat[i]);
                    end
                end
            end
            if (!rrise) begin
                for (int i = 0; i < ND; i++) begin
                    if (fr[i]) trem[i] = TW;
                    else if (trem[i] > 0) trem[i]--;
                end
            end
            for (int i = 3; i > 0; i--) begin hp[i] = hp[i-1]; hr[i] = hr[i-1]; end
            hp[0] = pulse_in;
            hr[0] = resync_in;
        end
    end

    // Compare every clock, away from the active edge
    int rises [ND];
    bit [ND-1:0] prev_trig = '0;

    always @(negedge clk) begin
        logic [ND-1:0] et, eg;
        int b;
        b = bar_of(m_d16);
        for (int i = 0; i < ND; i++) begin
            et[i] = m_run && (trem[i] > 0);
            if (!m_run) eg[i] = 0;
            else if (m_raw) eg[i] = (rat[i] == 1) ? hp[1] : ((m_cnt % rat[i]) < rat[i] / 2);
            else eg[i] = ((m_cnt * rat[i]) % b) < (b / 2);
            if (trig_o[i] && !prev_trig[i]) rises[i]++;
        end
        prev_trig = trig_o;
        if (rst_n) begin
            chk(trig_o === et, {tag, " R6"}, "trig_o", int'(trig_o), int'(et));
            chk(gate_o === eg, {tag, m_raw ? " R7 R8" : " R7"}, "gate_o", int'(gate_o), int'(eg));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic one_pulse(input int hi, input int lo);
        pulse_in = 1'b1;
        repeat (hi) @(negedge clk);
        pulse_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) one_pulse(10, 10);
    endtask

    task automatic snap(output int s [ND]);
        #1;
        for (int i = 0; i < ND; i++) s[i] = rises[i];
    endtask

    task automatic do_resync();
        resync_in = 1'b1;
        repeat (4) @(negedge clk);
        resync_in = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk(trig_o == '0 && gate_o == '0, "R10", "outputs after resync",
            int'({trig_o, gate_o}), 0);
    endtask

    initial begin
        int s0 [ND];
        int s1 [ND];
        int exp_raw [ND];

        // R9: quiet after reset, before any pulse
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            chk(trig_o == '0 && gate_o == '0, "R9", "idle outputs", int'({trig_o, gate_o}), 0);
        end

        // R5, R4: defaults give musical mode at 24; R2 latency on the first pulse
        tag = "R4 R5";
        snap(s0);
        pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk); #1;
        chk(trig_o == '0, "R2", "trig after two edges", int'(trig_o), 0);
        @(negedge clk); #1;
        chk(trig_o == '1, "R2", "trig after three edges", int'(trig_o), 127);
        repeat (7) @(negedge clk);
        pulse_in = 1'b0;
        repeat (10) @(negedge clk);
        pulses(95);
        snap(s1);
        for (int i = 0; i < ND; i++)
            chk(s1[i] - s0[i] == rat[i], "R1 R4 R5", $sformatf("musical24 starts /%0d", rat[i]),
                s1[i] - s0[i], rat[i]);
        pulses(20);

        // R10 resync, then R3 raw mode with R8 /1 gate
        do_resync();
        raw_mode = 1'b1;
        tag = "R3 R8";
        repeat (30) @(negedge clk);
        snap(s0);
        pulses(64);
        snap(s1);
        for (int i = 0; i < ND; i++) begin
            exp_raw[i] = (64 + rat[i] - 1) / rat[i];
            chk(s1[i] - s0[i] == exp_raw[i], "R3", $sformatf("raw starts /%0d", rat[i]),
                s1[i] - s0[i], exp_raw[i]);
        end

        // R11: switch to musical 16 mid-bar; raw holds until pulse 96
        raw_mode = 1'b0;
        dens_16 = 1'b1;
        tag = "R11";
        snap(s0);
        pulses(32);
        snap(s1);
        chk(s1[1] - s0[1] == 16, "R11", "raw /2 held", s1[1] - s0[1], 16);
        chk(s1[6] - s0[6] == 1, "R11", "raw /32 held", s1[6] - s0[6], 1);
        tag = "R4";
        snap(s0);
        pulses(64);
        snap(s1);
        for (int i = 0; i < ND; i++)
            chk(s1[i] - s0[i] == rat[i], "R4", $sformatf("musical16 starts /%0d", rat[i]),
                s1[i] - s0[i], rat[i]);

        // R6: pulses faster than the trigger width retrigger it
        tag = "R6";
        for (int k = 0; k < 40; k++) one_pulse(3, 3);
        repeat (20) @(negedge clk);

        // R2: a long high level counts as one pulse
        tag = "R2";
        one_pulse(200, 20);

        // R10: resync and stay idle
        tag = "R10";
        do_resync();
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); #1;
            chk(trig_o == '0 && gate_o == '0, "R10", "held quiet", int'({trig_o, gate_o}), 0);
        end
        finish_run();
    end

endmodule